// File: doc/BRIEF.md
# Sequenced Evidence Record Writer

This block appends fixed-format evidence records to a ring of slots in byte-addressable non-volatile memory. The memory is reached through a simple synchronous port: one byte per cycle, with read data returned on the cycle after the read strobe. Each request carries a kind code, a 4-bit severity, a duration byte and a 16-bit evidence snapshot. The block adds the current timestamp and a sequence number that rises by one for every record. It also adds a link field that holds the previous record's check value, and a CRC-16 over the record contents. A slot only counts once a final valid marker has been written after the body, so a power loss in the middle of a write leaves a slot that is plainly invalid and never one that is half valid.

After reset the block reads every slot and takes the valid slot with the highest sequence number as the head. It then reads the slot just before the head to confirm that the chain is unbroken. If the link, the sequence step or the integrity of that neighbour fails, the block appends a chain-break record of its own, built and protected like any other record, before it accepts requests. Timestamps that run backwards relative to the previous record are flagged, both in the stored record and on an output pulse.

Top module: `evlog_writer`

## Requirements
- R1: Each slot spans 16 bytes at address slot*16. Byte 0 is the marker. Byte 1 is the kind, byte 2 the level byte (bit 7 = time-rollback flag, bits 3:0 = severity, bits 6:4 zero), byte 3 the duration. Bytes 4-5 hold the sequence number, 6-7 the timestamp, 8-9 the link and 10-11 the snapshot, each 16-bit field least significant byte first.
- R2: Committed records carry sequence numbers that rise by exactly one, and the record with sequence s goes to slot s mod SLOTS.
- R3: Bytes 12 (high) and 13 (low) hold a CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first without reflection, over bytes 1 to 11.
- R4: The link field equals the stored CRC of the previous record; the first record written to an empty ring has link 0x0000.
- R5: A commit is exactly 15 writes to one slot: the marker byte cleared to 0x00, then bytes 1 to 13, then the marker set to 0xA5 last; any marker value other than 0xA5 means the slot is empty or invalid.
- R6: A request whose timestamp is below the previous record's timestamp sets bit 7 of the level byte, and rollback_o is high while that request is offered with ev_ready_o high.
- R7: After reset, ev_ready_o stays low while the ring is scanned, and the scan performs no memory writes when the chain is intact or the ring is empty.
- R8: The head is the slot with marker 0xA5, a matching CRC and the highest sequence number. Logging resumes with head sequence + 1, links to the head's CRC, and uses the head's timestamp as the rollback reference. An empty ring starts at sequence 0 in slot 0.
- R9: When the head sequence is above 0 and the slot before it is invalid, holds a sequence other than head-1, or has a CRC different from the head's link, one chain-break record is appended before ev_ready_o rises. That record has kind 0xEE, severity 0xF, duration 0, snapshot equal to the head sequence and timestamp time_i.
- R10: While a record is being written ev_ready_o is low, and requests offered then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the resume scan |
| time_i | input | 16 | Current time, used as record timestamp |
| ev_valid_i | input | 1 | Event request offered |
| ev_ready_o | output | 1 | Block idle and accepting a request |
| ev_kind_i | input | 8 | Event kind code |
| ev_level_i | input | 4 | Event severity |
| ev_dur_i | input | 8 | Event duration |
| ev_snap_i | input | 16 | Evidence snapshot |
| rollback_o | output | 1 | Offered request's timestamp is below the previous record's |
| mem_addr_o | output | clog2(SLOTS)+4 | Memory byte address |
| mem_re_o | output | 1 | Memory read strobe, data valid next cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
The writer is driven through a full lap of an 8-slot ring and beyond it, with rising timestamps and then a backwards step, so that slot wrap, link chaining and rollback flagging are each shown on their own. Resume is tried against four memory images: erased, intact, intact with a torn slot (wrong marker) and a forged slot (marker present but CRC wrong), and one whose head neighbour has an edited byte. These images separate the highest-sequence head choice, the rejection of invalid slots and the self-logged chain break. One request is held asserted through a whole commit to show that offers made while busy add no record.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
    localparam int          REC_IDX_W   = 4;        // 16-byte slot stride
    localparam logic [7:0]  MARK_OK     = 8'hA5;
    localparam logic [7:0]  MARK_CLR    = 8'h00;
    localparam logic [7:0]  KIND_BREAK  = 8'hEE;
    localparam logic [3:0]  LEVEL_BREAK = 4'hF;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [3:0]  IDX_CRC_HI  = 4'd12;
    localparam logic [3:0]  IDX_LAST    = 4'd13;
    localparam logic [3:0]  STEP_COMMIT = 4'd14;

    typedef enum logic [2:0] {
        ST_RD_ADDR,
        ST_RD_DATA,
        ST_RD_EVAL,
        ST_IDLE,
        ST_WRITE
    } evl_state_e;

    typedef struct packed {
        logic [7:0]  kind;
        logic [7:0]  level;
        logic [7:0]  dur;
        logic [15:0] seq;
        logic [15:0] ts;
        logic [15:0] link;
        logic [15:0] snap;
    } evl_rec_t;
endpackage

// File: rtl/evlog_crc_step.sv
module evlog_crc_step
    import evlog_pkg::*;
(
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    always_comb begin
        logic [15:0] c;
        c = crc_i ^ {byte_i, 8'h00};
        for (int b = 0; b < 8; b++) begin
            c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        crc_o = c;
    end
endmodule

// File: rtl/evlog_rec_fmt.sv
module evlog_rec_fmt
    import evlog_pkg::*;
(
    input  evl_rec_t               rec_i,
    input  logic [15:0]            crc_i,
    input  logic [REC_IDX_W-1:0]   idx_i,
    output logic [7:0]             byte_o
);
    always_comb begin
        case (idx_i)
            4'd1:    byte_o = rec_i.kind;
            4'd2:    byte_o = rec_i.level;
            4'd3:    byte_o = rec_i.dur;
            4'd4:    byte_o = rec_i.seq[7:0];
            4'd5:    byte_o = rec_i.seq[15:8];
            4'd6:    byte_o = rec_i.ts[7:0];
            4'd7:    byte_o = rec_i.ts[15:8];
            4'd8:    byte_o = rec_i.link[7:0];
            4'd9:    byte_o = rec_i.link[15:8];
            4'd10:   byte_o = rec_i.snap[7:0];
            4'd11:   byte_o = rec_i.snap[15:8];
            4'd12:   byte_o = crc_i[15:8];
            4'd13:   byte_o = crc_i[7:0];
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/evlog_writer.sv
module evlog_writer
    import evlog_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [15:0]                         time_i,
    input  logic                                ev_valid_i,
    output logic                                ev_ready_o,
    input  logic [7:0]                          ev_kind_i,
    input  logic [3:0]                          ev_level_i,
    input  logic [7:0]                          ev_dur_i,
    input  logic [15:0]                         ev_snap_i,
    output logic                                rollback_o,
    output logic [$clog2(SLOTS)+REC_IDX_W-1:0]  mem_addr_o,
    output logic                                mem_re_o,
    output logic                                mem_we_o,
    output logic [7:0]                          mem_wdata_o,
    input  logic [7:0]                          mem_rdata_i
);
    localparam int                SLOT_W    = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        evl_state_e           state;
        logic                 chk;        // reading head's neighbour
        logic [SLOT_W-1:0]    slot;       // read pointer
        logic [SLOT_W-1:0]    wslot;      // write pointer
        logic [REC_IDX_W-1:0] idx;        // byte index / write step
        logic [15:0]          crc;
        logic [7:0]           cap_mark;
        logic [15:0]          cap_seq;
        logic [15:0]          cap_ts;
        logic [15:0]          cap_link;
        logic [15:0]          cap_crc;
        logic                 found;
        logic [SLOT_W-1:0]    best_slot;
        logic [15:0]          best_seq;
        logic [15:0]          best_ts;
        logic [15:0]          best_link;
        logic [15:0]          best_crc;
        logic [15:0]          next_seq;
        logic [15:0]          prev_crc;
        logic [15:0]          last_ts;
        evl_rec_t             wr;
    } regs_t;

    regs_t q, d;

    logic [7:0]  fmt_byte;
    logic [7:0]  crc_in;
    logic [15:0] crc_nx;
    logic        in_body;

    evlog_rec_fmt u_fmt (
        .rec_i  (q.wr),
        .crc_i  (q.crc),
        .idx_i  (q.idx),
        .byte_o (fmt_byte)
    );

    assign crc_in  = (q.state == ST_WRITE) ? fmt_byte : mem_rdata_i;
    assign in_body = (q.idx >= 4'd1) && (q.idx <= 4'd11);

    evlog_crc_step u_crc (
        .crc_i  (q.crc),
        .byte_i (crc_in),
        .crc_o  (crc_nx)
    );

    assign ev_ready_o = (q.state == ST_IDLE);
    assign rollback_o = ev_ready_o && ev_valid_i && (time_i < q.last_ts);

    always_comb begin
        logic ok;
        logic brk;
        d           = q;
        mem_re_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = 8'h00;
        mem_addr_o  = {q.slot, q.idx};
        ok          = (q.cap_mark == MARK_OK) && (q.cap_crc == q.crc);
        brk         = 1'b0;

        case (q.state)
            ST_RD_ADDR: begin
                mem_re_o = 1'b1;
                d.state  = ST_RD_DATA;
            end

            ST_RD_DATA: begin
                if (in_body) d.crc = crc_nx;
                case (q.idx)
                    4'd0:  d.cap_mark       = mem_rdata_i;
                    4'd4:  d.cap_seq[7:0]   = mem_rdata_i;
                    4'd5:  d.cap_seq[15:8]  = mem_rdata_i;
                    4'd6:  d.cap_ts[7:0]    = mem_rdata_i;
                    4'd7:  d.cap_ts[15:8]   = mem_rdata_i;
                    4'd8:  d.cap_link[7:0]  = mem_rdata_i;
                    4'd9:  d.cap_link[15:8] = mem_rdata_i;
                    4'd12: d.cap_crc[15:8]  = mem_rdata_i;
                    4'd13: d.cap_crc[7:0]   = mem_rdata_i;
                    default: ;
                endcase
                if (q.idx == IDX_LAST) begin
                    d.state = ST_RD_EVAL;
                end else begin
                    d.idx   = q.idx + 4'd1;
                    d.state = ST_RD_ADDR;
                end
            end

            ST_RD_EVAL: begin
                d.idx = '0;
                d.crc = CRC_SEED;
                if (!q.chk) begin
                    if (ok && (!q.found || (q.cap_seq > q.best_seq))) begin
                        d.found     = 1'b1;
                        d.best_slot = q.slot;
                        d.best_seq  = q.cap_seq;
                        d.best_ts   = q.cap_ts;
                        d.best_link = q.cap_link;
                        d.best_crc  = q.cap_crc;
                    end
                    if (q.slot == LAST_SLOT) begin
                        if (!d.found) begin
                            d.next_seq = '0;
                            d.prev_crc = '0;
                            d.last_ts  = '0;
                            d.wslot    = '0;
                            d.state    = ST_IDLE;
                        end else begin
                            d.next_seq = d.best_seq + 16'd1;
                            d.prev_crc = d.best_crc;
                            d.last_ts  = d.best_ts;
                            d.wslot    = (d.best_slot == LAST_SLOT) ? '0 : d.best_slot + 1'b1;
                            if (d.best_seq == 16'd0) begin
                                d.state = ST_IDLE;
                            end else begin
                                d.chk   = 1'b1;
                                d.slot  = (d.best_slot == '0) ? LAST_SLOT : d.best_slot - 1'b1;
                                d.state = ST_RD_ADDR;
                            end
                        end
                    end else begin
                        d.slot  = q.slot + 1'b1;
                        d.state = ST_RD_ADDR;
                    end
                end else begin
                    brk = !ok || (q.cap_seq != q.best_seq - 16'd1) || (q.cap_crc != q.best_link);
                    if (brk) begin
                        d.wr.kind  = KIND_BREAK;
                        d.wr.level = {(time_i < q.last_ts), 3'b000, LEVEL_BREAK};
                        d.wr.dur   = 8'h00;
                        d.wr.seq   = q.next_seq;
                        d.wr.ts    = time_i;
                        d.wr.link  = q.prev_crc;
                        d.wr.snap  = q.best_seq;
                        d.state    = ST_WRITE;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
            end

            ST_IDLE: begin
                if (ev_valid_i) begin
                    d.wr.kind  = ev_kind_i;
                    d.wr.level = {(time_i < q.last_ts), 3'b000, ev_level_i};
                    d.wr.dur   = ev_dur_i;
                    d.wr.seq   = q.next_seq;
                    d.wr.ts    = time_i;
                    d.wr.link  = q.prev_crc;
                    d.wr.snap  = ev_snap_i;
                    d.idx      = '0;
                    d.crc      = CRC_SEED;
                    d.state    = ST_WRITE;
                end
            end

            ST_WRITE: begin
                mem_we_o   = 1'b1;
                mem_addr_o = {q.wslot, (q.idx == STEP_COMMIT) ? 4'd0 : q.idx};
                if (q.idx == 4'd0)             mem_wdata_o = MARK_CLR;
                else if (q.idx == STEP_COMMIT) mem_wdata_o = MARK_OK;
                else                           mem_wdata_o = fmt_byte;
                if (in_body) d.crc = crc_nx;
                if (q.idx == STEP_COMMIT) begin
                    d.next_seq = q.next_seq + 16'd1;
                    d.prev_crc = q.crc;
                    d.last_ts  = q.wr.ts;
                    d.wslot    = (q.wslot == LAST_SLOT) ? '0 : q.wslot + 1'b1;
                    d.idx      = '0;
                    d.state    = ST_IDLE;
                end else begin
                    d.idx = q.idx + 4'd1;
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_RD_ADDR;
            q.crc   <= CRC_SEED;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/evlog_writer_chk.sv
module evlog_writer_chk
    import evlog_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                ev_valid_i,
    input logic                                ev_ready_o,
    input logic                                rollback_o,
    input logic [$clog2(SLOTS)+REC_IDX_W-1:0]  mem_addr_o,
    input logic                                mem_re_o,
    input logic                                mem_we_o,
    input logic [7:0]                          mem_wdata_o
);
    logic [4:0] wcnt;
    logic       is_clear;
    logic       is_commit;

    assign is_clear  = mem_we_o && (mem_addr_o[REC_IDX_W-1:0] == '0) && (mem_wdata_o == MARK_CLR);
    assign is_commit = mem_we_o && (mem_addr_o[REC_IDX_W-1:0] == '0) && (mem_wdata_o == MARK_OK);

    always_ff @(posedge clk) begin
        if (!rst_n)        wcnt <= '0;
        else if (is_clear) wcnt <= 5'd1;
        else if (mem_we_o) wcnt <= wcnt + 5'd1;
    end

    assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready_o |-> (!mem_we_o && !mem_re_o));

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ready_o && !ev_valid_i) |=> ev_ready_o);

    assert_clear_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |-> is_clear);

    assert_commit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_commit |-> (wcnt == 5'd14));

    assert_commit_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_commit |=> ev_ready_o);

    assert_rollback_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_o |-> (ev_ready_o && ev_valid_i));
endmodule

bind evlog_writer evlog_writer_chk #(.SLOTS(SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid_i  (ev_valid_i),
    .ev_ready_o  (ev_ready_o),
    .rollback_o  (rollback_o),
    .mem_addr_o  (mem_addr_o),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o)
);

// File: tb/evlog_writer_test.sv
`timescale 1ns/1ps
module evlog_writer_test;
    localparam int SLOTS = 8;
    localparam int AW    = $clog2(SLOTS) + 4;
    localparam int DEPTH = SLOTS * 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [15:0]   time_i = '0;
    logic          ev_valid_i = 1'b0;
    logic          ev_ready_o;
    logic [7:0]    ev_kind_i = '0;
    logic [3:0]    ev_level_i = '0;
    logic [7:0]    ev_dur_i = '0;
    logic [15:0]   ev_snap_i = '0;
    logic          rollback_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_re_o, mem_we_o;
    logic [7:0]    mem_wdata_o;
    logic [7:0]    mem_rdata = '0;

    evlog_writer #(.SLOTS(SLOTS)) uut (
        .clk(clk), .rst_n(rst_n), .time_i(time_i),
        .ev_valid_i(ev_valid_i), .ev_ready_o(ev_ready_o),
        .ev_kind_i(ev_kind_i), .ev_level_i(ev_level_i), .ev_dur_i(ev_dur_i),
        .ev_snap_i(ev_snap_i), .rollback_o(rollback_o),
        .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
    );

    // memory model with poke port and commit-order monitor
    logic [7:0]    mem [DEPTH];
    logic          fill = 1'b0, poke = 1'b0;
    logic [AW-1:0] poke_addr = '0;
    logic [7:0]    poke_data = '0;
    int total = 0, bad = 0, mtot = 0, mbad = 0, wr_total = 0, wcnt = 0;

    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (poke) begin
            mem[poke_addr] <= poke_data;
        end
        if (mem_re_o) mem_rdata <= mem[mem_addr_o];
        if (mem_we_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            wr_total++;
            if (mem_addr_o[3:0] == 4'd0 && mem_wdata_o == 8'h00) wcnt = 1;
            else wcnt++;
            if (mem_addr_o[3:0] == 4'd0 && mem_wdata_o == 8'hA5) begin
                mtot++;
                if (wcnt != 15) begin
                    mbad++;
                    $display("FAIL R5 writes per commit: actual=%0d expected=15", wcnt);
                end
            end
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] calc_crc(input int slot);
        logic [15:0] c = 16'hFFFF;
        for (int b = 1; b <= 11; b++) begin
            c = c ^ {mem[slot*16+b], 8'h00};
            for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    function automatic int rd16(input int addr);
        return {mem[addr+1], mem[addr]};
    endfunction

    task automatic check_rec(input int slot, input int kind, input int level, input int dur,
                             input int seq, input int ts, input int link, input int snap);
        int base = slot * 16;
        check_eq("R5", "marker", mem[base], 8'hA5);
        check_eq("R1", "kind", mem[base+1], kind);
        check_eq("R1", "level byte", mem[base+2], level);
        check_eq("R1", "duration", mem[base+3], dur);
        check_eq("R2", "sequence", rd16(base+4), seq);
        check_eq("R1", "timestamp", rd16(base+6), ts);
        check_eq("R4", "link", rd16(base+8), link);
        check_eq("R1", "snapshot", rd16(base+10), snap);
        check_eq("R3", "crc", {mem[base+12], mem[base+13]}, calc_crc(slot));
    endtask

    int exp_seq = 0, exp_prev = 0, exp_last = 0;

    task automatic wait_ready();
        int n = 0;
        @(negedge clk);
        while (!ev_ready_o && n < 3000) begin @(negedge clk); n++; end
        if (!ev_ready_o) check_eq("R7", "ready timeout", 0, 1);
    endtask

    // offer one request, verify the committed record (R1..R6, R10)
    task automatic send(input int kind, input int lvl, input int dur, input int ts,
                        input int snap, input bit hold);
        int w0;
        int roll;
        wait_ready();
        w0 = wr_total;
        time_i = 16'(ts); ev_kind_i = 8'(kind); ev_level_i = 4'(lvl);
        ev_dur_i = 8'(dur); ev_snap_i = 16'(snap); ev_valid_i = 1'b1;
        #1;
        roll = (ts < exp_last) ? 1 : 0;
        check_eq("R6", "rollback_o", int'(rollback_o), roll);
        @(negedge clk);
        if (hold) begin
            ev_kind_i = 8'h77;
            for (int i = 0; i < 5; i++) begin
                check_eq("R10", "ready while busy", int'(ev_ready_o), 0);
                @(negedge clk);
            end
        end
        ev_valid_i = 1'b0;
        wait_ready();
        check_eq("R5", "writes for one record", wr_total - w0, 15);
        check_rec(exp_seq % SLOTS, kind, (roll << 7) | lvl, dur, exp_seq, ts, exp_prev, snap);
        exp_prev = calc_crc(exp_seq % SLOTS);
        exp_last = ts;
        exp_seq++;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_eq("R7", "ready during scan", int'(ev_ready_o), 0);
    endtask

    task automatic poke_byte(input int addr, input int val);
        @(negedge clk); poke_addr = AW'(addr); poke_data = 8'(val); poke = 1'b1;
        @(negedge clk); poke = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total + mtot, bad + mbad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        int w0;
        // erased memory, reset state
        fill = 1'b1;
        @(negedge clk); fill = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_eq("R7", "ready right after reset", int'(ev_ready_o), 0);
        check_eq("R7", "no write after reset", int'(mem_we_o), 0);
        w0 = wr_total;
        wait_ready();
        check_eq("R8", "empty ring scan writes", wr_total - w0, 0);

        // more than a full lap of the ring, one request held while busy
        for (int k = 0; k < 10; k++)
            send(k + 1, k % 16, 3 * k, 100 + 10 * k, 16'h1000 + k, k == 2);

        // time runs backwards, then forwards again
        send(8'h30, 5, 1, 50, 16'hBEEF, 1'b0);
        send(8'h31, 6, 2, 60, 16'hCAFE, 1'b0);

        // intact resume: no writes, continues with restored state
        do_reset();
        w0 = wr_total;
        wait_ready();
        check_eq("R9", "intact resume writes", wr_total - w0, 0);
        send(8'h40, 1, 0, 40, 16'h4444, 1'b0);   // rollback versus restored timestamp (R8)

        // torn slot (bad marker) and forged slot (high seq, bad crc) are ignored
        poke_byte(5 * 16 + 0, 8'h5A);
        poke_byte(5 * 16 + 4, 8'h99);
        poke_byte(6 * 16 + 5, 8'h70);
        do_reset();
        w0 = wr_total;
        wait_ready();
        check_eq("R8", "resume with invalid slots writes", wr_total - w0, 0);
        send(8'h41, 2, 9, 45, 16'h5151, 1'b0);

        // edit the head's neighbour: a chain-break record is appended
        poke_byte(4 * 16 + 10, 8'h77);
        time_i = 16'd500;
        do_reset();
        w0 = wr_total;
        wait_ready();
        check_eq("R9", "break record writes", wr_total - w0, 15);
        check_rec(exp_seq % SLOTS, 8'hEE, 8'h0F, 0, exp_seq, 500, exp_prev, exp_seq - 1);
        exp_prev = calc_crc(exp_seq % SLOTS);
        exp_last = 500;
        exp_seq++;
        send(8'h42, 3, 4, 510, 16'h6262, 1'b0);

        // chain is whole again after the break record
        do_reset();
        w0 = wr_total;
        wait_ready();
        check_eq("R9", "resume after break writes", wr_total - w0, 0);
        send(8'h43, 4, 5, 520, 16'h7373, 1'b0);   // wraps to slot 0

        finish_run();
    end
endmodule